// File: doc/BRIEF.md
# Floating-Point Exception Flag Accumulator

This block sits beside a floating-point datapath and turns the per-operation status word of each finished operation into sticky flag bits of a control/status register. Thirteen individual cause bits arrive with an operation-done strobe. They fold into eight flags: a general invalid-operation flag, separate signalling-NaN and quiet-NaN flags, an infinity flag, and one flag each for overflow, underflow, divide-by-zero and inexact.

Flags only accumulate while the exception-enable input is high. After an accumulating update, if any flag is set, the block raises a one-cycle exception request. The request carries the program counter of the previous instruction, which was sampled with the strobe. Software clears or rewrites the flags through a write port. A hardware update in the same cycle is merged on top of the written value, so no event is lost. The arithmetic itself lies outside the block.

Top module: `fpx_flag_accum`

## Requirements
- R1: While reset is asserted and after reset is released, `flags_o` is 0, `exc_req_o` is 0 and `exc_pc_o` is 0.
- R2: On an update (`op_done_i` and `fp_exc_en_i` both high), flag bit 0 (invalid) is set if any of cause bits 0 to 8 is set. Cause bit 0 is signalling NaN, 1 quiet NaN, 2 inf minus inf, 3 inf divided by inf, 4 zero divided by zero, 5 inf times zero, 6 invalid conversion, 7 invalid compare and 8 invalid square root.
- R3: On an update, flag bit 1 (signalling NaN) is set only by cause bit 0, and flag bit 2 (quiet NaN) only by cause bit 1.
- R4: On an update, flag bit 5 (infinity) is set by cause bit 2 or cause bit 3, and by no other cause.
- R5: On an update, the remaining causes each set their own flag: cause bit 9 (overflow) sets flag bit 3, bit 10 (underflow) sets flag bit 4, bit 11 (divide by zero) sets flag bit 6, and bit 12 (inexact) sets flag bit 7.
- R6: When `op_done_i` or `fp_exc_en_i` is low, the cause vector has no effect on `flags_o` and no request is raised.
- R7: Flags are sticky. Flag bits set by hardware stay set until a software write, and new updates OR into the existing flags.
- R8: A software write (`sw_wr_i`) loads `sw_flags_i` into the flags on the next edge. A write of zero clears them. If an update happens in the same cycle, its flags are ORed on top of the written value.
- R9: After an update that leaves any flag set, `exc_req_o` is high for exactly the next cycle and `exc_pc_o` equals the `prev_pc_i` sampled with that update. Otherwise `exc_pc_o` holds its last value.
- R10: An update that leaves all eight flags clear raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_done_i | input | 1 | A floating-point operation completed this cycle |
| op_cause_i | input | 13 | Per-operation cause bits (positions in R2 to R5) |
| fp_exc_en_i | input | 1 | Floating-point exception enable |
| prev_pc_i | input | PC_W | Program counter of the previous instruction |
| sw_wr_i | input | 1 | Software write strobe for the flags |
| sw_flags_i | input | 8 | Flag value written by software |
| flags_o | output | 8 | Sticky flags: 0 invalid, 1 sNaN, 2 qNaN, 3 overflow, 4 underflow, 5 infinity, 6 divide-by-zero, 7 inexact |
| exc_req_o | output | 1 | One-cycle floating-point exception request |
| exc_pc_o | output | PC_W | Program counter attached to the request |

## Verification
Each of the thirteen cause bits is first applied alone, against cleared flags. This separates the causes that must reach both the invalid flag and a specific flag from those that reach only the invalid flag. Directed patterns then try every cause with the enable low and with the strobe low, a software write colliding with an update, and an update with an empty cause vector, both over set flags and over cleared flags. The empty-vector cases tell apart a request driven by the sticky state from one driven by the new causes alone. A long run of seeded random strobes, sparse cause vectors and occasional writes then tracks the accumulated flags and the request against a bench model.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int CAUSE_W = 13;
    localparam int FLAG_W  = 8;

    // cause bit positions
    localparam int C_SNAN  = 0;
    localparam int C_QNAN  = 1;
    localparam int C_ISI   = 2;
    localparam int C_IDI   = 3;
    localparam int C_ZDZ   = 4;
    localparam int C_IMZ   = 5;
    localparam int C_CVI   = 6;
    localparam int C_CMP   = 7;
    localparam int C_SQRT  = 8;
    localparam int C_OVF   = 9;
    localparam int C_UNF   = 10;
    localparam int C_DIVZ  = 11;
    localparam int C_INEX  = 12;

    // flag bit positions
    localparam int F_INV   = 0;
    localparam int F_SNAN  = 1;
    localparam int F_QNAN  = 2;
    localparam int F_OVF   = 3;
    localparam int F_UNF   = 4;
    localparam int F_INF   = 5;
    localparam int F_DIVZ  = 6;
    localparam int F_INEX  = 7;

    typedef logic [CAUSE_W-1:0] cause_t;
    typedef logic [FLAG_W-1:0]  flags_t;

    // Set of cause bits feeding a given flag.
    function automatic cause_t src_mask(input int flag_idx);
        cause_t m;
        m = '0;
        case (flag_idx)
            F_INV: begin
                for (int c = C_SNAN; c <= C_SQRT; c++) begin
                    m[c] = 1'b1;
                end
            end
            F_SNAN: m[C_SNAN] = 1'b1;
            F_QNAN: m[C_QNAN] = 1'b1;
            F_OVF:  m[C_OVF]  = 1'b1;
            F_UNF:  m[C_UNF]  = 1'b1;
            F_INF: begin
                m[C_ISI] = 1'b1;
                m[C_IDI] = 1'b1;
            end
            F_DIVZ: m[C_DIVZ] = 1'b1;
            F_INEX: m[C_INEX] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fpx_cause_fold.sv
module fpx_cause_fold
    import fpx_pkg::*;
(
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [FLAG_W-1:0]  set_o
);

    for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
        localparam cause_t MASK = src_mask(f);
        assign set_o[f] = |(cause_i & MASK);
    end

endmodule

// File: rtl/fpx_flag_state.sv
module fpx_flag_state
    import fpx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              upd_i,
    input  logic [FLAG_W-1:0] set_i,
    input  logic              wr_i,
    input  logic [FLAG_W-1:0] wr_data_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] flags_next_o
);

    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        flags_t base;
        state_d = state_q;
        base    = wr_i ? wr_data_i : state_q.flags;
        state_d.flags = base | (upd_i ? set_i : '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o      = state_q.flags;
    assign flags_next_o = state_d.flags;

endmodule

// File: rtl/fpx_exc_req.sv
module fpx_exc_req
    import fpx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              upd_i,
    input  logic [FLAG_W-1:0] flags_next_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic              req_o,
    output logic [PC_W-1:0]   pc_o
);

    typedef struct packed {
        logic            req;
        logic [PC_W-1:0] pc;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.req = upd_i && (|flags_next_i);
        if (state_d.req) begin
            state_d.pc = pc_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_o = state_q.req;
    assign pc_o  = state_q.pc;

endmodule

// File: rtl/fpx_flag_accum.sv
module fpx_flag_accum
    import fpx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               op_done_i,
    input  logic [CAUSE_W-1:0] op_cause_i,
    input  logic               fp_exc_en_i,
    input  logic [PC_W-1:0]    prev_pc_i,
    input  logic               sw_wr_i,
    input  logic [FLAG_W-1:0]  sw_flags_i,
    output logic [FLAG_W-1:0]  flags_o,
    output logic               exc_req_o,
    output logic [PC_W-1:0]    exc_pc_o
);

    logic              upd;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flags_next;

    assign upd = op_done_i && fp_exc_en_i;

    fpx_cause_fold u_fold (
        .cause_i (op_cause_i),
        .set_o   (set_vec)
    );

    fpx_flag_state u_state (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .upd_i        (upd),
        .set_i        (set_vec),
        .wr_i         (sw_wr_i),
        .wr_data_i    (sw_flags_i),
        .flags_o      (flags_o),
        .flags_next_o (flags_next)
    );

    fpx_exc_req #(.PC_W(PC_W)) u_req (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .upd_i        (upd),
        .flags_next_i (flags_next),
        .pc_i         (prev_pc_i),
        .req_o        (exc_req_o),
        .pc_o         (exc_pc_o)
    );

endmodule

// File: rtl/fpx_flag_chk.sv
module fpx_flag_chk
    import fpx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               op_done_i,
    input logic [CAUSE_W-1:0] op_cause_i,
    input logic               fp_exc_en_i,
    input logic [PC_W-1:0]    prev_pc_i,
    input logic               sw_wr_i,
    input logic [FLAG_W-1:0]  sw_flags_i,
    input logic [FLAG_W-1:0]  flags_o,
    input logic               exc_req_o,
    input logic [PC_W-1:0]    exc_pc_o
);

    always_comb begin
        if (!rst_ni) begin
            AST_RESET_CLEAR: assert (flags_o == '0 && !exc_req_o && exc_pc_o == '0); // R1
        end
    end

    AST_SNAN_FOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_done_i && fp_exc_en_i && op_cause_i[C_SNAN])
        |=> (flags_o[F_INV] && flags_o[F_SNAN])); // R3

    AST_INF_FOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_done_i && fp_exc_en_i && (op_cause_i[C_ISI] || op_cause_i[C_IDI]))
        |=> (flags_o[F_INV] && flags_o[F_INF])); // R4

    AST_IGNORED_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(op_done_i && fp_exc_en_i) && !sw_wr_i) |=> ($stable(flags_o) && !exc_req_o)); // R6

    AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sw_wr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R7

    AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_wr_i && !(op_done_i && fp_exc_en_i)) |=> (flags_o == $past(sw_flags_i))); // R8

    AST_WRITE_KEEPS_HW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_wr_i |=> ((flags_o & $past(sw_flags_i)) == $past(sw_flags_i))); // R8

    AST_REQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_done_i && fp_exc_en_i) |=> (!exc_req_o || exc_pc_o == $past(prev_pc_i))); // R9

    AST_REQ_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_req_o |-> (flags_o != '0)); // R10

    AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exc_req_o |-> $stable(exc_pc_o)); // R9

endmodule

bind fpx_flag_accum fpx_flag_chk #(.PC_W(PC_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_done_i   (op_done_i),
    .op_cause_i  (op_cause_i),
    .fp_exc_en_i (fp_exc_en_i),
    .prev_pc_i   (prev_pc_i),
    .sw_wr_i     (sw_wr_i),
    .sw_flags_i  (sw_flags_i),
    .flags_o     (flags_o),
    .exc_req_o   (exc_req_o),
    .exc_pc_o    (exc_pc_o)
);

// File: tb/fpx_flag_accum_tb_top.sv
module fpx_flag_accum_tb_top;

    localparam int PC_W = 32;
    localparam int WATCHDOG_CYC = 200000;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            op_done_i = 1'b0;
    logic [12:0]     op_cause_i = '0;
    logic            fp_exc_en_i = 1'b0;
    logic [PC_W-1:0] prev_pc_i = '0;
    logic            sw_wr_i = 1'b0;
    logic [7:0]      sw_flags_i = '0;
    logic [7:0]      flags_o;
    logic            exc_req_o;
    logic [PC_W-1:0] exc_pc_o;

    int checks = 0;
    int errors = 0;
    logic [7:0]      model_flags = '0;
    logic [PC_W-1:0] model_pc = '0;

    always #4 clk_i = ~clk_i;

    fpx_flag_accum #(.PC_W(PC_W)) dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_done_i   (op_done_i),
        .op_cause_i  (op_cause_i),
        .fp_exc_en_i (fp_exc_en_i),
        .prev_pc_i   (prev_pc_i),
        .sw_wr_i     (sw_wr_i),
        .sw_flags_i  (sw_flags_i),
        .flags_o     (flags_o),
        .exc_req_o   (exc_req_o),
        .exc_pc_o    (exc_pc_o)
    );

    function automatic logic [7:0] fold(input logic [12:0] s);
        logic [7:0] f;
        f[0] = |s[8:0];
        f[1] = s[0];
        f[2] = s[1];
        f[3] = s[9];
        f[4] = s[10];
        f[5] = s[2] | s[3];
        f[6] = s[11];
        f[7] = s[12];
        return f;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // Called at a falling edge; drives, waits one cycle, checks.
    task automatic apply(input string tag, input logic op, input logic [12:0] st,
                         input logic en, input logic [PC_W-1:0] pc,
                         input logic wr, input logic [7:0] wd);
        logic       upd;
        logic [7:0] nxt;
        logic       ereq;
        op_done_i = op; op_cause_i = st; fp_exc_en_i = en;
        prev_pc_i = pc; sw_wr_i = wr; sw_flags_i = wd;
        upd  = op && en;
        nxt  = (wr ? wd : model_flags) | (upd ? fold(st) : 8'h00);
        ereq = upd && (nxt != 8'h00);
        if (ereq) model_pc = pc;
        model_flags = nxt;
        @(negedge clk_i);
        check(tag, "flags", 64'(flags_o), 64'(nxt));
        check(tag, "req", 64'(exc_req_o), 64'(ereq));
        check(tag, "pc", 64'(exc_pc_o), 64'(model_pc));
    endtask

    task automatic idle();
        op_done_i = 1'b0; sw_wr_i = 1'b0; op_cause_i = '0;
    endtask

    initial begin
        #(8 * WATCHDOG_CYC);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));

        // R1: reset state
        repeat (3) @(negedge clk_i);
        check("R1", "flags in reset", 64'(flags_o), 64'h0);
        check("R1", "req in reset", 64'(exc_req_o), 64'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1", "flags after reset", 64'(flags_o), 64'h0);
        check("R1", "pc after reset", 64'(exc_pc_o), 64'h0);

        // R2..R5: each cause alone on cleared flags
        for (int k = 0; k < 13; k++) begin
            string tag;
            if (k == 0 || k == 1) tag = "R3";
            else if (k == 2 || k == 3) tag = "R4";
            else if (k >= 9) tag = "R5";
            else tag = "R2";
            apply("R8", 1'b0, '0, 1'b1, 32'h0, 1'b1, 8'h00);
            apply(tag, 1'b1, 13'(1) << k, 1'b1, 32'h1000 + 32'(k) * 4, 1'b0, 8'h00);
        end

        // R6: enable low, and strobe low, with every cause
        apply("R8", 1'b0, '0, 1'b1, 32'h0, 1'b1, 8'h00);
        apply("R6", 1'b1, 13'h1fff, 1'b0, 32'h2000, 1'b0, 8'h00);
        apply("R6", 1'b0, 13'h1fff, 1'b1, 32'h2004, 1'b0, 8'h00);

        // R7: sticky accumulation, empty update over set flags still requests
        apply("R7", 1'b1, 13'(1) << 9, 1'b1, 32'h3000, 1'b0, 8'h00);
        apply("R7", 1'b1, 13'(1) << 12, 1'b1, 32'h3004, 1'b0, 8'h00);
        apply("R9", 1'b1, 13'h0, 1'b1, 32'h3008, 1'b0, 8'h00);
        apply("R9", 1'b0, 13'h0, 1'b1, 32'h300c, 1'b0, 8'h00);

        // R8: write colliding with update, then plain write
        apply("R8", 1'b1, 13'(1) << 11, 1'b1, 32'h4000, 1'b1, 8'h10);
        apply("R8", 1'b0, '0, 1'b1, 32'h0, 1'b1, 8'ha5);

        // R10: clear then empty update -> no request
        apply("R8", 1'b0, '0, 1'b1, 32'h0, 1'b1, 8'h00);
        apply("R10", 1'b1, 13'h0, 1'b1, 32'h5000, 1'b0, 8'h00);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [12:0] st;
            st = 13'($urandom & $urandom & $urandom);
            apply("R7", ($urandom % 4) != 0, st, ($urandom % 4) != 0,
                  $urandom, ($urandom % 16) == 0, 8'($urandom & $urandom));
        end

        idle();
        @(negedge clk_i);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule